// File: doc/BRIEF.md
# Slot-Stream Pixel Reassembler

This block sits on the receiving side of a serial video link, after the deserializer and deframer. It takes a stream of 16-bit payload slots and rebuilds parallel pixels from them. Each slot carries a frame-start flag and a dummy flag. A pixel is a fixed number of colour bits. Depending on the configured control mode, three control bits may follow the colour bits. The control bits are horizontal sync, vertical sync and data enable. The width and the control mode are static settings, and they must match the settings used when the stream was packed.

After reset the block is unaligned and drops everything it decodes. It becomes aligned when the first pixel of a frame marks alignment. In the control modes that pixel must carry data enable high; in the mode without control bits, the frame start alone is enough. From then on it pushes every pixel to a downstream buffer through a valid/ready pair. Every new frame start throws away leftover partial bits and restarts unpacking at the slot boundary. This lets the block recover from corrupted or lost bits. When the sink holds off, the block stalls the slot input instead of dropping data.

Top module: `pix_reassembler`

## Requirements
- R1: While reset is high and in the cycle after it falls, pix_valid, aligned and de_short_err are 0, realign_cnt is 0, and slot_ready is 1 for a non-dummy slot.
- R2: Slot bits are consumed most significant bit first. A pixel is W colour bits, with W = 10, 12, 18 or 24 for cfg_width 00, 01, 10 or 11. The first colour bit received is the pixel's MSB. pix_data is the pixel zero-extended to 24 bits.
- R3: When control bits are carried, they are the 3 bits right after a pixel's colour bits, in the order hsync, vsync, data enable. cfg_ctl_mode 11 carries them on every pixel. Mode 10 carries them on pixels with even index, counted from 0 at each frame start. Modes 00 and 01 never carry them. A pixel without control bits outputs the control values last received.
- R4: A slot with slot_dummy=1 is always accepted, and its data and frame-start flag have no effect on the output.
- R5: After reset no pixel is output and aligned stays 0. Alignment starts at the first pixel of a frame whose data enable bit is 1; in modes 00/01 it starts at any frame start. That pixel is output, aligned goes to 1, and aligned stays 1 until reset.
- R6: A frame-start slot discards all partial pixel bits held and restarts the pixel index at 0. Its MSB is the first bit of the frame's first pixel.
- R7: realign_cnt counts the pixels that start or renew alignment, saturating at its maximum.
- R8: If a run of 1 to 3 output pixels with data enable 1 is followed by an output pixel with data enable 0, de_short_err goes to 1 and stays there until reset. Runs of 4 or more never set it.
- R9: While pix_valid=1 and pix_ready=0, the output pixel and its control bits stay unchanged. No pixel is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 2 | Pixel width code |
| cfg_ctl_mode | input | 2 | Control-bit carriage mode |
| slot_valid | input | 1 | Slot present |
| slot_ready | output | 1 | Slot accepted this cycle when valid |
| slot_data | input | SLOT_W | Slot payload, MSB first |
| slot_first | input | 1 | Slot starts a frame |
| slot_dummy | input | 1 | Slot is filler |
| pix_valid | output | 1 | Output pixel present |
| pix_ready | input | 1 | Sink takes the pixel |
| pix_data | output | PIX_W | Pixel, zero-extended |
| pix_hsync | output | 1 | Horizontal sync |
| pix_vsync | output | 1 | Vertical sync |
| pix_de | output | 1 | Data enable |
| aligned | output | 1 | Alignment acquired |
| realign_cnt | output | CNT_W | Alignment event count |
| de_short_err | output | 1 | Sticky short data-enable flag |

## Verification
The bench packs random frames in every width and mode. Each frame ends with random filler bits that must be thrown away at the next frame start. A design that kept those bits would shift every pixel that follows. Filler slots carry random data and a random frame-start flag, so a design that honoured either would corrupt pixels or re-synchronise at the wrong place. Frames whose first pixel lacks data enable and slots sent before any frame start check that nothing leaks out before alignment. A short data-enable burst and an exact four-pixel burst check both sides of the error threshold. Random backpressure catches changed held data and lost or duplicated pixels.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int CTL_W = 3;

  typedef enum logic [1:0] {
    CTL_NEVER = 2'b00,
    CTL_RSVD  = 2'b01,
    CTL_EVEN  = 2'b10,
    CTL_EVERY = 2'b11
  } ctl_mode_e;

  function automatic int unsigned width_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 10;
      2'b01:   return 12;
      2'b10:   return 18;
      default: return 24;
    endcase
  endfunction

  function automatic logic ctl_carried(input logic [1:0] mode, input logic odd);
    return (mode == CTL_EVERY) || ((mode == CTL_EVEN) && !odd);
  endfunction
endpackage

// File: rtl/pr_bitbuf.sv
module pr_bitbuf #(
  parameter int SLOT_W = 16,
  parameter int PIX_W  = 24,
  parameter int CTL_W  = 3,
  parameter int ACC_W  = 42,
  parameter int NEED_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              take_first,
  input  logic [SLOT_W-1:0] take_data,
  input  logic              pop,
  input  logic [NEED_W-1:0] pix_bits,
  input  logic [NEED_W-1:0] need,
  output logic              room,
  output logic              have,
  output logic [PIX_W-1:0]  head_pix,
  output logic [CTL_W-1:0]  head_ctl
);
  logic [ACC_W-1:0]  acc;
  logic [NEED_W-1:0] cnt;
  logic [ACC_W-1:0]  ext;

  assign ext  = {take_data, {(ACC_W-SLOT_W){1'b0}}} >> cnt;
  assign room = cnt < need;
  assign have = !room;

  assign head_pix = PIX_W'(acc >> (NEED_W'(ACC_W) - pix_bits));
  assign head_ctl = CTL_W'(acc >> (NEED_W'(ACC_W) - pix_bits - NEED_W'(CTL_W)));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cnt <= '0;
    end else if (take) begin
      if (take_first) begin
        acc <= {take_data, {(ACC_W-SLOT_W){1'b0}}};
        cnt <= NEED_W'(SLOT_W);
      end else begin
        acc <= acc | ext;
        cnt <= cnt + NEED_W'(SLOT_W);
      end
    end else if (pop) begin
      acc <= acc << need;
      cnt <= cnt - need;
    end
  end
endmodule

// File: rtl/pr_align.sv
module pr_align #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first_take,
  input  logic             pop,
  input  logic             has_ctl,
  input  logic             head_de,
  output logic             keep_head,
  output logic             pix_odd,
  output logic             aligned,
  output logic [CNT_W-1:0] realign_cnt
);
  logic first_pend;
  logic mark_ok;

  assign mark_ok   = first_pend && (!has_ctl || head_de);
  assign keep_head = aligned || mark_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_pend  <= 1'b0;
      pix_odd     <= 1'b0;
      aligned     <= 1'b0;
      realign_cnt <= '0;
    end else if (first_take) begin
      first_pend <= 1'b1;
      pix_odd    <= 1'b0;
    end else if (pop) begin
      first_pend <= 1'b0;
      pix_odd    <= !pix_odd;
      if (mark_ok) begin
        aligned <= 1'b1;
        if (realign_cnt != {CNT_W{1'b1}})
          realign_cnt <= realign_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pr_de_check.sv
module pr_de_check #(
  parameter int RUN_MIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic emit,
  input  logic de_val,
  output logic err
);
  localparam int RUN_BW = $clog2(RUN_MIN + 1);
  logic [RUN_BW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
      err <= 1'b0;
    end else if (emit) begin
      if (de_val) begin
        if (run != RUN_BW'(RUN_MIN)) run <= run + 1'b1;
      end else begin
        if (run != '0 && run < RUN_BW'(RUN_MIN)) err <= 1'b1;
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/pix_reassembler.sv
module pix_reassembler
  import pr_pkg::*;
#(
  parameter int SLOT_W  = 16,
  parameter int PIX_W   = 24,
  parameter int CNT_W   = 8,
  parameter int RUN_MIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_width,
  input  logic [1:0]        cfg_ctl_mode,
  input  logic              slot_valid,
  output logic              slot_ready,
  input  logic [SLOT_W-1:0] slot_data,
  input  logic              slot_first,
  input  logic              slot_dummy,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_hsync,
  output logic              pix_vsync,
  output logic              pix_de,
  output logic              aligned,
  output logic [CNT_W-1:0]  realign_cnt,
  output logic              de_short_err
);
  localparam int ACC_W  = PIX_W + CTL_W + SLOT_W - 1;
  localparam int NEED_W = $clog2(ACC_W + 1);

  logic              room, have, take, pop, out_free;
  logic              has_ctl, pix_odd, keep_head;
  logic [NEED_W-1:0] pix_bits, need;
  logic [PIX_W-1:0]  head_pix;
  logic [CTL_W-1:0]  head_ctl, held_ctl, out_ctl;

  assign pix_bits   = NEED_W'(width_bits(cfg_width));
  assign has_ctl    = ctl_carried(cfg_ctl_mode, pix_odd);
  assign need       = pix_bits + (has_ctl ? NEED_W'(CTL_W) : '0);
  assign slot_ready = slot_dummy || room;
  assign take       = slot_valid && !slot_dummy && room;
  assign out_free   = !pix_valid || pix_ready;
  assign pop        = have && (!keep_head || out_free);
  assign out_ctl    = has_ctl ? head_ctl : held_ctl;

  pr_bitbuf #(
    .SLOT_W(SLOT_W), .PIX_W(PIX_W), .CTL_W(CTL_W), .ACC_W(ACC_W), .NEED_W(NEED_W)
  ) u_buf (
    .clk(clk), .rst(rst), .take(take), .take_first(slot_first),
    .take_data(slot_data), .pop(pop), .pix_bits(pix_bits), .need(need),
    .room(room), .have(have), .head_pix(head_pix), .head_ctl(head_ctl)
  );

  pr_align #(.CNT_W(CNT_W)) u_align (
    .clk(clk), .rst(rst), .first_take(take && slot_first), .pop(pop),
    .has_ctl(has_ctl), .head_de(head_ctl[0]), .keep_head(keep_head),
    .pix_odd(pix_odd), .aligned(aligned), .realign_cnt(realign_cnt)
  );

  pr_de_check #(.RUN_MIN(RUN_MIN)) u_de (
    .clk(clk), .rst(rst), .emit(pop && keep_head), .de_val(out_ctl[0]),
    .err(de_short_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_hsync <= 1'b0;
      pix_vsync <= 1'b0;
      pix_de    <= 1'b0;
      held_ctl  <= '0;
    end else begin
      if (pop && has_ctl) held_ctl <= head_ctl;
      if (pop && keep_head) begin
        pix_valid <= 1'b1;
        pix_data  <= head_pix;
        {pix_hsync, pix_vsync, pix_de} <= out_ctl;
      end else if (pix_ready) begin
        pix_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pr_checker.sv
module pr_checker #(
  parameter int SLOT_W = 16,
  parameter int PIX_W  = 24,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_width,
  input logic              slot_valid,
  input logic              slot_ready,
  input logic              slot_dummy,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [PIX_W-1:0]  pix_data,
  input logic              pix_hsync,
  input logic              pix_vsync,
  input logic              pix_de,
  input logic              aligned,
  input logic [CNT_W-1:0]  realign_cnt,
  input logic              de_short_err
);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_data) &&
      $stable({pix_hsync, pix_vsync, pix_de}));

  p_gate_r5: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> aligned);

  p_keep_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    aligned |=> aligned);

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    de_short_err |=> de_short_err);

  p_cnt_up_r7: assert property (@(posedge clk) disable iff (rst)
    aligned |=> realign_cnt >= $past(realign_cnt));

  p_cnt_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    realign_cnt != '0 |-> aligned);

  p_zext_r2: assert property (@(posedge clk) disable iff (rst)
    pix_valid && cfg_width != 2'b11 |-> pix_data[PIX_W-1:18] == '0);

  p_dummy_r4: assert property (@(posedge clk) disable iff (rst)
    slot_valid && slot_dummy |-> slot_ready);
endmodule

bind pix_reassembler pr_checker #(.SLOT_W(SLOT_W), .PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_width(cfg_width), .slot_valid(slot_valid),
  .slot_ready(slot_ready), .slot_dummy(slot_dummy), .pix_valid(pix_valid),
  .pix_ready(pix_ready), .pix_data(pix_data), .pix_hsync(pix_hsync),
  .pix_vsync(pix_vsync), .pix_de(pix_de), .aligned(aligned),
  .realign_cnt(realign_cnt), .de_short_err(de_short_err)
);

// File: tb/tb_pix_reassembler.sv
module tb_pix_reassembler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_width = 2'b11;
  logic [1:0]  cfg_ctl_mode = 2'b11;
  logic        slot_valid = 1'b0;
  logic        slot_ready;
  logic [15:0] slot_data = '0;
  logic        slot_first = 1'b0;
  logic        slot_dummy = 1'b0;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic [23:0] pix_data;
  logic        pix_hsync, pix_vsync, pix_de;
  logic        aligned;
  logic [7:0]  realign_cnt;
  logic        de_short_err;

  pix_reassembler dut (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_ctl_mode(cfg_ctl_mode),
    .slot_valid(slot_valid), .slot_ready(slot_ready), .slot_data(slot_data),
    .slot_first(slot_first), .slot_dummy(slot_dummy), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .pix_hsync(pix_hsync),
    .pix_vsync(pix_vsync), .pix_de(pix_de), .aligned(aligned),
    .realign_cnt(realign_cnt), .de_short_err(de_short_err)
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stream and expectation storage
  bit [15:0]   s_data [0:4095];
  bit          s_first[0:4095];
  bit          s_dummy[0:4095];
  int          ns;
  logic [26:0] e_pix [0:4095];
  int          ne;
  logic [15:0] cur;
  int          nbit;
  bit          next_first;
  // requirement model state
  bit          m_aligned, m_err, m_odd;
  int          m_cnt, m_run;
  logic [2:0]  m_held;

  function automatic int wbits(input logic [1:0] wc);
    case (wc) 2'b00: return 10; 2'b01: return 12; 2'b10: return 18; default: return 24; endcase
  endfunction

  function automatic bit carried(input logic [1:0] md, input bit odd);
    return (md == 2'b11) || (md == 2'b10 && !odd);
  endfunction

  function automatic int need_of(input logic [1:0] wc, input logic [1:0] md, input bit odd);
    return wbits(wc) + (carried(md, odd) ? 3 : 0);
  endfunction

  task automatic put_bit(input bit b);
    cur[15-nbit] = b;
    nbit++;
    if (nbit == 16) begin
      if ($urandom % 5 == 0) begin
        s_data[ns] = 16'($urandom); s_first[ns] = 1'($urandom); s_dummy[ns] = 1; ns++;
      end
      s_data[ns] = cur; s_first[ns] = next_first; s_dummy[ns] = 0; ns++;
      next_first = 0; nbit = 0; cur = '0;
    end
  endtask

  task automatic put_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic add_pixel(input logic [1:0] wc, input logic [1:0] md,
                           input logic [23:0] d, input logic [2:0] ctl, input bit is_first);
    bit has;
    logic [2:0] ec;
    has = carried(md, m_odd);
    put_bits({8'h0, d}, wbits(wc));
    if (has) put_bits({29'h0, ctl}, 3);
    ec = has ? ctl : m_held;
    if (has) m_held = ctl;
    if (is_first && (!has || ctl[0])) begin
      m_aligned = 1;
      if (m_cnt < 255) m_cnt++;
    end
    if (m_aligned) begin
      e_pix[ne] = {d, ec}; ne++;
      if (ec[0]) begin
        if (m_run < 4) m_run++;
      end else begin
        if (m_run > 0 && m_run < 4) m_err = 1;
        m_run = 0;
      end
    end
    m_odd = !m_odd;
  endtask

  task automatic gen_frame(input logic [1:0] wc, input logic [1:0] md, input int npix, input int de_len);
    int lft;
    next_first = 1; m_odd = 0;
    for (int i = 0; i < npix; i++)
      add_pixel(wc, md, 24'($urandom) & 24'((1 << wbits(wc)) - 1),
                {1'($urandom), 1'($urandom), 1'(i < de_len)}, i == 0);
    // trailing bits up to the slot boundary: zero pixels if they fit, else random filler (R6)
    while (nbit != 0) begin
      lft = 16 - nbit;
      if (lft >= need_of(wc, md, m_odd)) add_pixel(wc, md, 24'h0, 3'b000, 0);
      else put_bits($urandom, lft);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; slot_valid = 0; slot_dummy = 0; slot_first = 0; pix_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    ns = 0; ne = 0; nbit = 0; cur = '0; next_first = 0;
    m_aligned = 0; m_err = 0; m_odd = 0; m_cnt = 0; m_run = 0; m_held = '0;
  endtask

  task automatic run_stream(input int rdy_pct);
    int si = 0, ei = 0, guard = 0;
    bit stall = 0;
    logic [26:0] prev = '0;
    while ((si < ns || ei < ne) && guard < 20000) begin
      @(negedge clk);
      guard++;
      slot_valid = (si < ns) && ($urandom % 4 != 0);
      if (si < ns) begin
        slot_data = s_data[si]; slot_first = s_first[si]; slot_dummy = s_dummy[si];
      end
      pix_ready = ($urandom % 100) < rdy_pct;
      #1;
      if (stall)
        chk(pix_valid && {pix_data, pix_hsync, pix_vsync, pix_de} == prev, "R9 held pixel",
            {4'h0, pix_data, pix_hsync, pix_vsync, pix_de}, {5'h0, prev});
      if (pix_valid && pix_ready) begin
        if (ei < ne) chk({pix_data, pix_hsync, pix_vsync, pix_de} == e_pix[ei], "R2 R3 R6 pixel",
                         {5'h0, pix_data, pix_hsync, pix_vsync, pix_de}, {5'h0, e_pix[ei]});
        else chk(0, "R5 unexpected pixel", {8'h0, pix_data}, 32'h0);
        ei++;
      end
      stall = pix_valid && !pix_ready;
      prev  = {pix_data, pix_hsync, pix_vsync, pix_de};
      if (slot_valid && slot_dummy) chk(slot_ready, "R4 dummy accepted", 32'(slot_ready), 1);
      if (slot_valid && slot_ready) si++;
    end
    chk(guard < 20000, "R9 stream drained", guard, 20000);
    @(negedge clk);
    slot_valid = 0; pix_ready = 1;
    for (int k = 0; k < 20; k++) begin
      #1;
      if (pix_valid) chk(0, "R5 extra pixel", {8'h0, pix_data}, 32'h0);
      @(negedge clk);
    end
  endtask

  task automatic end_checks(input string tag);
    chk(aligned == m_aligned, {"R5 aligned ", tag}, 32'(aligned), 32'(m_aligned));
    chk(realign_cnt == 8'(m_cnt), {"R7 count ", tag}, 32'(realign_cnt), m_cnt);
    chk(de_short_err == m_err, {"R8 error flag ", tag}, 32'(de_short_err), 32'(m_err));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // directed: reset state, pre-alignment silence, DE thresholds
    cfg_width = 2'b11; cfg_ctl_mode = 2'b11;
    do_reset();
    #1;
    chk(!pix_valid, "R1 pix_valid", 32'(pix_valid), 0);
    chk(!aligned, "R1 aligned", 32'(aligned), 0);
    chk(realign_cnt == 0, "R1 realign_cnt", 32'(realign_cnt), 0);
    chk(!de_short_err, "R1 error", 32'(de_short_err), 0);
    chk(slot_ready, "R1 slot_ready", 32'(slot_ready), 1);
    for (int k = 0; k < 4; k++) put_bits(0, 16);   // slots before any frame start
    gen_frame(2'b11, 2'b11, 6, 0);                 // first pixel without data enable
    run_stream(80);
    chk(!aligned, "R5 still unaligned", 32'(aligned), 0);
    chk(ne == 0, "R5 nothing expected", ne, 0);
    ns = 0; ne = 0;
    gen_frame(2'b11, 2'b11, 10, 4);                // exact minimum run: no error
    run_stream(60);
    end_checks("first lock");
    chk(de_short_err == 0, "R8 four-pixel run", 32'(de_short_err), 0);
    ns = 0; ne = 0;
    gen_frame(2'b11, 2'b11, 6, 2);                 // short run
    run_stream(100);
    chk(de_short_err == 1, "R8 short run", 32'(de_short_err), 1);
    end_checks("short run");

    // random frames over every width and mode
    for (int w = 0; w < 4; w++) begin
      for (int md = 0; md < 4; md++) begin
        cfg_width = 2'(w); cfg_ctl_mode = 2'(md);
        do_reset();
        for (int f = 0; f < 3; f++) begin
          int np;
          np = 6 + int'($urandom % 12);
          gen_frame(2'(w), 2'(md), np, 4 + int'($urandom % (np - 5)));
        end
        run_stream(md == 1 ? 100 : 30 + int'($urandom % 70));
        end_checks($sformatf("w%0d m%0d", w, md));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule